// File: doc/BRIEF.md
# Circular Descriptor Queue Tracker

This block follows the fill level of a circular descriptor ring that is shared between software, which produces descriptors, and a hardware consumer, which processes them. Software issues a one-cycle enqueue strobe each time it moves its write position forward. The consumer issues a dequeue strobe each time it retires a descriptor. The block holds both ring positions and derives empty, full and overflow status from them. It also raises two sticky interrupt flags, one for queue-full and one for queue-overflow, and each has its own enable.

The ring length is chosen by a 4-bit size code that sets a power of two from 2 to 2048 entries. The size code is stored only while the controller enable is low. Dropping the enable returns the ring to its empty start state.

Overflow detection works only in chaining mode. Outside chaining mode, an enqueue presented to a full ring is dropped. The descriptor storage, the descriptor contents and any bus access lie outside this block.

Top module: `cdq_tracker`

## Requirements
- R1: A stored size code c from 0 to 10 gives a ring of 2<<c entries. Both positions count 0 up to the ring length minus one, then wrap back to 0. Codes 11 to 15 are handled as a ring of 2 entries.
- R2: A size_wr strobe stores size_code only while ctl_en is low. While ctl_en is high, the strobe is ignored. size_cfg always shows the stored raw code.
- R3: An accepted enqueue adds one to wr_pos at the next clock edge. If the two positions are equal after the enqueue, q_full is set and q_empty is cleared.
- R4: A dequeue on a non-empty ring adds one to rd_pos and clears q_full. If the positions are equal after the dequeue, q_empty is set. A dequeue while q_empty is set is ignored.
- R5: In chaining mode (chain_mode high), an enqueue alone on a full ring still moves wr_pos. In that case q_full clears and q_ovf is set. q_ovf stays set until the controller is disabled.
- R6: With chain_mode low, an enqueue alone on a full ring is dropped. wr_pos, q_full and q_ovf stay unchanged.
- R7: full_irq is set at the clock edge after a cycle in which both full_ie and q_full are high. It is never set while full_ie is low. It stays set until a clr_full_irq strobe. If the set condition is present in the same cycle as the strobe, the set condition wins.
- R8: ovf_irq is set by an overflow event (R5) while ovf_ie is high. It is not set by an overflow while ovf_ie is low. It stays set until a clr_ovf_irq strobe, and a new overflow wins over a clear in the same cycle.
- R9: While ctl_en is low, both positions are 0 from the next edge onward. In that state q_empty is 1, and q_full, q_ovf, full_irq and ovf_irq are 0.
- R10: An enqueue together with a dequeue on a non-empty ring moves both positions and leaves q_empty and q_full unchanged, with no overflow, even when the ring is full. The same pair on an empty ring acts as an enqueue alone.
- R11: After synchronous reset, size_cfg is 0, both positions are 0, and q_empty is 1. All other status bits and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_en | input | 1 | Controller enable; low holds the ring empty and allows size changes |
| chain_mode | input | 1 | High selects chaining mode, which allows overflow |
| size_wr | input | 1 | Strobe to store size_code |
| size_code | input | 4 | Ring size code |
| enq | input | 1 | Software enqueue strobe |
| deq | input | 1 | Consumer dequeue strobe |
| full_ie | input | 1 | Queue-full interrupt enable |
| ovf_ie | input | 1 | Queue-overflow interrupt enable |
| clr_full_irq | input | 1 | Write-one-to-clear strobe for full_irq |
| clr_ovf_irq | input | 1 | Write-one-to-clear strobe for ovf_irq |
| size_cfg | output | 4 | Stored size code |
| wr_pos | output | 11 | Enqueue position |
| rd_pos | output | 11 | Dequeue position |
| q_empty | output | 1 | Ring empty |
| q_full | output | 1 | Ring full |
| q_ovf | output | 1 | Overflow seen (sticky) |
| full_irq | output | 1 | Queue-full interrupt flag |
| ovf_irq | output | 1 | Queue-overflow interrupt flag |

## Verification
An enqueue and a dequeue can arrive in the same cycle. This is provoked on a full ring, on a part-filled ring and on an empty ring. On the full ring, the bench expects both positions to move while full stays set and no overflow appears. On the empty ring, the bench expects only the enqueue to take effect. A second collision is an interrupt-clear strobe in the same cycle as a persisting full condition. The bench judges that case by the flag remaining set.

// File: rtl/cdq_pkg.sv
// Package: shared types for the circular descriptor queue tracker.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package cdq_pkg;
    localparam int unsigned CDQ_PTR_W  = 11;
    localparam int unsigned CDQ_CODE_W = 4;

    typedef struct packed {
        logic empty;
        logic full;
        logic ovf;
    } cdq_stat_t;

    typedef enum logic [1:0] {
        MV_IDLE = 2'b00,
        MV_DEQ  = 2'b01,
        MV_ENQ  = 2'b10,
        MV_BOTH = 2'b11
    } cdq_move_e;
endpackage

// File: rtl/cdq_size_cfg.sv
// Module: holds the ring size code and derives the position wrap mask.
// Assumes: the code is writable only while the controller is disabled;
// codes above PTR_W-1 select the smallest ring of two entries.
module cdq_size_cfg #(
    parameter int unsigned PTR_W  = 11,
    parameter int unsigned CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              size_wr,
    input  logic [CODE_W-1:0] size_code,
    output logic [CODE_W-1:0] size_cfg,
    output logic [PTR_W-1:0]  wrap_mask
);
    localparam int MAX_CODE = int'(PTR_W) - 1;

    logic [CODE_W-1:0] code_q;
    int                eff;

    // Store a new size code only while the controller is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (!ctl_en && size_wr) begin
            code_q <= size_code;
        end
    end

    // Build the wrap mask: ones in bits 0..eff, reserved codes map to eff 0.
    always_comb begin
        eff = (int'(code_q) > MAX_CODE) ? 0 : int'(code_q);
        for (int i = 0; i < int'(PTR_W); i++) begin
            wrap_mask[i] = (i <= eff);
        end
    end

    assign size_cfg = code_q;
endmodule

// File: rtl/cdq_ptr.sv
// Module: one ring position counter that wraps through a power-of-two mask.
// Assumes: the mask is contiguous ones from bit 0; a disabled controller
// holds the position at zero.
module cdq_ptr #(
    parameter int unsigned PTR_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_en,
    input  logic             adv,
    input  logic [PTR_W-1:0] wrap_mask,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_inc
);
    // Next position after one advance, wrapped to the ring length.
    always_comb begin
        ptr_inc = (ptr + PTR_W'(1)) & wrap_mask;
    end

    // Hold, clear or advance the position.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_en) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= ptr_inc;
        end
    end
endmodule

// File: rtl/cdq_status.sv
// Module: decides which strobes are accepted and keeps empty/full/overflow
// status plus the two sticky interrupt flags.
// Assumes: positions are registered elsewhere and presented with their
// wrapped successors; a ring has at least two entries.
module cdq_status
    import cdq_pkg::*;
#(
    parameter int unsigned PTR_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_en,
    input  logic             chain_mode,
    input  logic             enq,
    input  logic             deq,
    input  logic             full_ie,
    input  logic             ovf_ie,
    input  logic             clr_full_irq,
    input  logic             clr_ovf_irq,
    input  logic [PTR_W-1:0] wr_pos,
    input  logic [PTR_W-1:0] rd_pos,
    input  logic [PTR_W-1:0] wr_inc,
    input  logic [PTR_W-1:0] rd_inc,
    output logic             enq_go,
    output logic             deq_go,
    output cdq_stat_t        stat,
    output logic             full_irq,
    output logic             ovf_irq
);
    cdq_move_e move;
    logic      ovf_ev;
    cdq_stat_t stat_nx;

    // Accept strobes: no dequeue from empty, no enqueue into full outside chaining.
    always_comb begin
        deq_go = deq && !stat.empty;
        enq_go = enq && (!stat.full || deq_go || chain_mode);
        ovf_ev = enq && stat.full && !deq_go && chain_mode;
        move   = cdq_move_e'({enq_go, deq_go});
    end

    // Next status from the kind of move and the positions after it.
    always_comb begin
        stat_nx = stat;
        unique case (move)
            MV_ENQ: begin
                stat_nx.empty = 1'b0;
                stat_nx.full  = (wr_inc == rd_pos);
                if (ovf_ev) begin
                    stat_nx.ovf = 1'b1;
                end
            end
            MV_DEQ: begin
                stat_nx.full  = 1'b0;
                stat_nx.empty = (rd_inc == wr_pos);
            end
            default: ;
        endcase
    end

    // Status register, cleared on reset and while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_en) begin
            stat <= '{empty: 1'b1, full: 1'b0, ovf: 1'b0};
        end else begin
            stat <= stat_nx;
        end
    end

    // Sticky interrupt flags, set condition wins over the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_en) begin
            full_irq <= 1'b0;
            ovf_irq  <= 1'b0;
        end else begin
            full_irq <= (full_irq && !clr_full_irq) || (full_ie && stat.full);
            ovf_irq  <= (ovf_irq && !clr_ovf_irq) || (ovf_ie && ovf_ev);
        end
    end
endmodule

// File: rtl/cdq_tracker.sv
// Module: top of the circular descriptor queue tracker. Wires the size
// register, two position counters and the status/interrupt logic.
// Assumes: enq/deq are single-cycle strobes, synchronous to clk.
module cdq_tracker
    import cdq_pkg::*;
#(
    parameter int unsigned PTR_W  = CDQ_PTR_W,
    parameter int unsigned CODE_W = CDQ_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              chain_mode,
    input  logic              size_wr,
    input  logic [CODE_W-1:0] size_code,
    input  logic              enq,
    input  logic              deq,
    input  logic              full_ie,
    input  logic              ovf_ie,
    input  logic              clr_full_irq,
    input  logic              clr_ovf_irq,
    output logic [CODE_W-1:0] size_cfg,
    output logic [PTR_W-1:0]  wr_pos,
    output logic [PTR_W-1:0]  rd_pos,
    output logic              q_empty,
    output logic              q_full,
    output logic              q_ovf,
    output logic              full_irq,
    output logic              ovf_irq
);
    localparam int NPTR = 2;

    logic [PTR_W-1:0] wrap_mask;
    logic             adv   [NPTR];
    logic [PTR_W-1:0] pos   [NPTR];
    logic [PTR_W-1:0] inc   [NPTR];
    logic             enq_go;
    logic             deq_go;
    cdq_stat_t        stat;

    cdq_size_cfg #(.PTR_W(PTR_W), .CODE_W(CODE_W)) u_size (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_en    (ctl_en),
        .size_wr   (size_wr),
        .size_code (size_code),
        .size_cfg  (size_cfg),
        .wrap_mask (wrap_mask)
    );

    // Index 0 is the enqueue position, index 1 the dequeue position.
    assign adv[0] = enq_go;
    assign adv[1] = deq_go;

    for (genvar g = 0; g < NPTR; g++) begin : g_pos
        cdq_ptr #(.PTR_W(PTR_W)) u_ptr (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_en    (ctl_en),
            .adv       (adv[g]),
            .wrap_mask (wrap_mask),
            .ptr       (pos[g]),
            .ptr_inc   (inc[g])
        );
    end

    cdq_status #(.PTR_W(PTR_W)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_en       (ctl_en),
        .chain_mode   (chain_mode),
        .enq          (enq),
        .deq          (deq),
        .full_ie      (full_ie),
        .ovf_ie       (ovf_ie),
        .clr_full_irq (clr_full_irq),
        .clr_ovf_irq  (clr_ovf_irq),
        .wr_pos       (pos[0]),
        .rd_pos       (pos[1]),
        .wr_inc       (inc[0]),
        .rd_inc       (inc[1]),
        .enq_go       (enq_go),
        .deq_go       (deq_go),
        .stat         (stat),
        .full_irq     (full_irq),
        .ovf_irq      (ovf_irq)
    );

    assign wr_pos  = pos[0];
    assign rd_pos  = pos[1];
    assign q_empty = stat.empty;
    assign q_full  = stat.full;
    assign q_ovf   = stat.ovf;
endmodule

// File: rtl/cdq_tracker_chk.sv
// Module: property checker for cdq_tracker, attached through bind.
// Assumes: it sees only the top-level ports.
module cdq_tracker_chk #(
    parameter int unsigned PTR_W  = 11,
    parameter int unsigned CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_en,
    input logic              chain_mode,
    input logic              size_wr,
    input logic              enq,
    input logic              deq,
    input logic              full_ie,
    input logic              ovf_ie,
    input logic [CODE_W-1:0] size_cfg,
    input logic [PTR_W-1:0]  wr_pos,
    input logic [PTR_W-1:0]  rd_pos,
    input logic              q_empty,
    input logic              q_full,
    input logic              q_ovf,
    input logic              full_irq,
    input logic              ovf_irq
);
    localparam int MAX_CODE = int'(PTR_W) - 1;

    logic [PTR_W-1:0] lim;
    int               c_eff;

    // Independent ring limit mask from the visible size code.
    always_comb begin
        c_eff = (int'(size_cfg) > MAX_CODE) ? 0 : int'(size_cfg);
        lim   = '0;
        for (int i = 0; i < int'(PTR_W); i++) begin
            if (i <= c_eff) lim[i] = 1'b1;
        end
    end

    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_pos & ~lim) == '0) && ((rd_pos & ~lim) == '0));
    p_size_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_en |=> $stable(size_cfg));
    p_full_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> (wr_pos == rd_pos));
    p_empty_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> (wr_pos == rd_pos && !q_full));
    p_ovf_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_ovf) |-> $past(chain_mode));
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && !chain_mode && q_full && enq && !deq)
        |=> ($stable(wr_pos) && $stable(q_ovf) && q_full));
    p_fi_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_ie && !full_irq) |=> !full_irq);
    p_oi_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_irq) |-> $past(ovf_ie && chain_mode));
    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (wr_pos == '0 && rd_pos == '0 && q_empty && !q_full
                     && !q_ovf && !full_irq && !ovf_irq));
    p_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && enq && deq && !q_empty) |=> ($stable(q_full) && $stable(q_empty)));
endmodule

bind cdq_tracker cdq_tracker_chk #(.PTR_W(PTR_W), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_en     (ctl_en),
    .chain_mode (chain_mode),
    .size_wr    (size_wr),
    .enq        (enq),
    .deq        (deq),
    .full_ie    (full_ie),
    .ovf_ie     (ovf_ie),
    .size_cfg   (size_cfg),
    .wr_pos     (wr_pos),
    .rd_pos     (rd_pos),
    .q_empty    (q_empty),
    .q_full     (q_full),
    .q_ovf      (q_ovf),
    .full_irq   (full_irq),
    .ovf_irq    (ovf_irq)
);

// File: tb/tb_cdq_tracker.sv
`timescale 1ns/100ps
module tb_cdq_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_en = 1'b0, chain_mode = 1'b0, size_wr = 1'b0;
    logic [3:0]  size_code = 4'd0;
    logic        enq = 1'b0, deq = 1'b0, full_ie = 1'b0, ovf_ie = 1'b0;
    logic        clr_full_irq = 1'b0, clr_ovf_irq = 1'b0;
    logic [3:0]  size_cfg;
    logic [10:0] wr_pos, rd_pos;
    logic        q_empty, q_full, q_ovf, full_irq, ovf_irq;

    cdq_tracker dut (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    string       q_tag [$];
    logic [30:0] q_val [$];

    // Model state, written from the requirements.
    int m_code = 0, m_e = 0, m_d = 0;
    bit m_emp = 1, m_full = 0, m_ovf = 0, m_fi = 0, m_oi = 0;

    function automatic int ring_len(int c);
        return (c > 10) ? 2 : (2 << c);
    endfunction

    function automatic logic [30:0] pack_model();
        return {4'(m_code), 11'(m_e), 11'(m_d), m_emp, m_full, m_ovf, m_fi, m_oi};
    endfunction

    function automatic logic [30:0] pack_dut();
        return {size_cfg, wr_pos, rd_pos, q_empty, q_full, q_ovf, full_irq, ovf_irq};
    endfunction

    task automatic compare(string tag, logic [30:0] act, logic [30:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual code=%0d wr=%0d rd=%0d e/f/o/fi/oi=%b expected code=%0d wr=%0d rd=%0d e/f/o/fi/oi=%b",
                     tag, act[30:27], act[26:16], act[15:5], act[4:0],
                     exp[30:27], exp[26:16], exp[15:5], exp[4:0]);
        end
    endtask

    // Driver: advance the model for the current inputs, queue the expectation, clock once.
    task automatic step(string tag);
        bit dgo, ego, oev;
        int sz, ne, nd;
        if (!ctl_en) begin
            if (size_wr) m_code = int'(size_code);
            m_e = 0; m_d = 0; m_emp = 1; m_full = 0; m_ovf = 0; m_fi = 0; m_oi = 0;
        end else begin
            sz  = ring_len(m_code);
            dgo = deq && !m_emp;
            oev = enq && m_full && !dgo && chain_mode;
            ego = enq && (!m_full || dgo || chain_mode);
            m_fi = (m_fi && !clr_full_irq) || (full_ie && m_full);
            m_oi = (m_oi && !clr_ovf_irq) || (ovf_ie && oev);
            ne = ego ? (m_e + 1) % sz : m_e;
            nd = dgo ? (m_d + 1) % sz : m_d;
            if (ego && !dgo) begin
                m_emp = 0; m_full = (ne == m_d);
                if (oev) m_ovf = 1;
            end else if (dgo && !ego) begin
                m_full = 0; m_emp = (nd == m_e);
            end
            m_e = ne; m_d = nd;
        end
        q_tag.push_back(tag);
        q_val.push_back(pack_model());
        @(negedge clk);
        enq = 0; deq = 0; size_wr = 0; clr_full_irq = 0; clr_ovf_irq = 0;
    endtask

    // Monitor: after each rising edge pop one expectation and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_val.size() > 0) compare(q_tag.pop_front(), pack_dut(), q_val.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R11 reset state", pack_dut(), pack_model());
        rst_n = 1;
        size_code = 4'd0; size_wr = 1; step("R2 size write while disabled");
        ctl_en = 1; chain_mode = 1; full_ie = 1; ovf_ie = 1; step("R9 enable");
        enq = 1; step("R3 first enqueue");
        enq = 1; step("R3 full after enqueue R1 wrap of 2");
        step("R7 full flag follows full");
        enq = 1; step("R5 overflow in chaining R8 flag");
        clr_full_irq = 1; clr_ovf_irq = 1; step("R8 clear flags");
        ctl_en = 0; step("R9 disable clears");
        size_code = 4'd2; size_wr = 1; step("R2 size 8");
        ctl_en = 1; step("R9 re-enable");
        for (int i = 0; i < 8; i++) begin enq = 1; step("R1 R3 fill 8-entry ring"); end
        step("R7 full flag");
        clr_full_irq = 1; step("R7 set wins over clear");
        enq = 1; deq = 1; step("R10 both on full ring");
        enq = 1; deq = 1; step("R10 both on full ring again");
        size_code = 4'd5; size_wr = 1; step("R2 write ignored while enabled");
        chain_mode = 0; enq = 1; step("R6 enqueue dropped when full");
        step("R6 hold");
        chain_mode = 1;
        for (int i = 0; i < 8; i++) begin deq = 1; step("R4 drain ring"); end
        deq = 1; step("R4 dequeue while empty ignored");
        enq = 1; deq = 1; step("R10 both on empty ring");
        enq = 1; step("R3 part fill");
        enq = 1; deq = 1; step("R10 both on part-filled ring");
        ctl_en = 0; full_ie = 0; ovf_ie = 0; step("R9 disable");
        size_code = 4'd12; size_wr = 1; step("R1 reserved code stored");
        ctl_en = 1; step("R9 enable reserved size");
        enq = 1; step("R1 reserved acts as 2");
        enq = 1; step("R1 reserved full at 2");
        step("R7 no full flag while disabled enable");
        enq = 1; step("R8 overflow with flag enable low");
        step("R8 no flag");
        ctl_en = 0; step("R9 disable");
        size_code = 4'd10; size_wr = 1; step("R2 size 2048");
        ctl_en = 1; step("R9 enable 2048");
        for (int i = 0; i < 2047; i++) begin enq = 1; step("R1 2048 fill"); end
        enq = 1; step("R1 R3 full at 2048");
        deq = 1; step("R4 dequeue clears full");
        ctl_en = 0; step("R9 final disable");
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule